// File: doc/BRIEF.md
# Sprite Attribute Store with Host Byte Port

This block keeps the per-sprite attributes for 128 sprites. It uses two memories that are packed in different ways. The primary table gives each sprite four bytes. The secondary table packs two extra bits for each sprite, so four sprites share every byte.

A host writes and reads both tables one byte at a time through a single auto-advancing pointer. The host first loads a 9-bit start address, made of a low byte and a separate top bit. It then issues write or read strobes. Each strobe moves the pointer to the next byte.

A renderer presents a 7-bit sprite index. One clock later it receives that sprite's fully decoded attributes. The decoder merges the two bits that live in the secondary table into the X coordinate and the size flag. It takes the top bit of the character number from the attribute byte.

Top module: `spr_attr_mem`

## Requirements
- R1: While reset is high, the pointer clears to 0. The host read data and every renderer output clear to 0.
- R2: A load strobe sets the pointer to {addr_hi, addr_lo} (range 0..511). A write or read strobe in the same cycle as a load is ignored: no byte is stored and read data is held.
- R3: A write strobe without a load stores wdata at the pointer. The pointer advances by one in the same clock edge.
- R4: A read strobe without a load or write puts the byte at the pointer on rdata after the next clock edge. The pointer advances by one. Without a completed read, rdata keeps its value.
- R5: Pointer values 0..511 address the primary table, where byte 4*s+k of sprite s holds: k=0 X low byte, k=1 Y, k=2 character low byte, k=3 attribute byte. Pointer values 512..543 address secondary byte b = pointer-512. That byte holds sprite s = 4*b+j in bits [2j+1:2j].
- R6: A step from pointer 543 goes to pointer 0, so the byte after the last secondary byte is primary byte 0.
- R7: When write and read strobe together without a load, only the write takes place. The pointer advances by exactly one, and rdata is held.
- R8: A sprite index presented in one cycle yields that sprite's decoded attributes on the renderer outputs after the next clock edge.
- R9: Attribute byte fields from bit 7 down: vertical flip (7), horizontal flip (6), priority (5:4), palette (3:1), character number bit 8 (0). The character number is {attr[0], character low byte}.
- R10: X is {pair bit 1, X low byte}, and the size toggle is pair bit 0. Here "pair" is the sprite's 2-bit field in the secondary table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ld | input | 1 | Load pointer strobe |
| addr_lo | input | 8 | Low byte of load address |
| addr_hi | input | 1 | Top bit of load address |
| host_wr | input | 1 | Byte write strobe |
| wdata | input | 8 | Byte to write |
| host_rd | input | 1 | Byte read strobe |
| rdata | output | 8 | Registered read byte |
| spr_idx | input | 7 | Renderer sprite index |
| spr_x | output | 9 | X coordinate |
| spr_y | output | 8 | Y coordinate |
| spr_chr | output | 9 | Character number |
| spr_pal | output | 3 | Palette |
| spr_pri | output | 2 | Priority |
| spr_hflip | output | 1 | Horizontal flip |
| spr_vflip | output | 1 | Vertical flip |
| spr_size | output | 1 | Size toggle |

## Verification
A host strobe moves the pointer at the same clock edge that samples it. A read byte is due one edge later. The bench drives every strobe on a falling edge and samples rdata on the following falling edge.

Renderer outputs are due one edge after the index is applied. The bench checks them half a cycle after that edge, across all 128 sprites.

Stepping effects are observed only through later reads. Examples are the 511-to-512 crossing, the 543-to-0 wrap and the single step on a joint write and read.

// File: rtl/spr_attr_pkg.sv
package spr_attr_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;

  // byte lane order within one sprite's primary record
  localparam int LANE_XLO  = 0;
  localparam int LANE_Y    = 1;
  localparam int LANE_CHR  = 2;
  localparam int LANE_ATTR = 3;

  typedef struct packed {
    logic [8:0] x;
    logic [7:0] y;
    logic [8:0] chr;
    logic [2:0] pal;
    logic [1:0] pri;
    logic       hflip;
    logic       vflip;
    logic       size;
  } spr_attr_t;
endpackage

// File: rtl/spr_byte_ram.sv
module spr_byte_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          ra_en,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data,
  input  logic          rb_en,
  input  logic [AW-1:0] rb_addr,
  output logic [7:0]    rb_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first registered ports, output registers reset to zero
  always_ff @(posedge clk) begin
    if (rst) begin
      ra_data <= '0;
      rb_data <= '0;
    end else begin
      if (ra_en) ra_data <= mem[ra_addr];
      if (rb_en) rb_data <= mem[rb_addr];
    end
  end
endmodule

// File: rtl/spr_host_ptr.sv
module spr_host_ptr #(
  parameter int TOTAL = 544,
  parameter int PTR_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (ld) begin
      ptr <= (ld_val > LAST) ? '0 : ld_val;
    end else if (step) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spr_attr_decode.sv
module spr_attr_decode
  import spr_attr_pkg::*;
(
  input  logic [7:0] b_xlo,
  input  logic [7:0] b_y,
  input  logic [7:0] b_chr,
  input  logic [7:0] b_attr,
  input  logic [7:0] b_aux,
  input  logic [1:0] pair_sel,
  output spr_attr_t  attr
);
  logic [1:0] pair;

  always_comb begin
    pair       = b_aux[2*pair_sel +: 2];
    attr.x     = {pair[1], b_xlo};
    attr.size  = pair[0];
    attr.y     = b_y;
    attr.chr   = {b_attr[0], b_chr};
    attr.pal   = b_attr[3:1];
    attr.pri   = b_attr[5:4];
    attr.hflip = b_attr[6];
    attr.vflip = b_attr[7];
  end
endmodule

// File: rtl/spr_attr_mem.sv
module spr_attr_mem
  import spr_attr_pkg::*;
#(
  parameter int N_SPR = 128,
  localparam int IDX_W      = $clog2(N_SPR),
  localparam int MAIN_BYTES = N_SPR * LANES,
  localparam int AUX_BYTES  = N_SPR / 4,
  localparam int LD_W       = $clog2(MAIN_BYTES),
  localparam int HI_W       = LD_W - 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_ld,
  input  logic [7:0]      addr_lo,
  input  logic [HI_W-1:0] addr_hi,
  input  logic            host_wr,
  input  logic [7:0]      wdata,
  input  logic            host_rd,
  output logic [7:0]      rdata,
  input  logic [IDX_W-1:0] spr_idx,
  output logic [8:0]      spr_x,
  output logic [7:0]      spr_y,
  output logic [8:0]      spr_chr,
  output logic [2:0]      spr_pal,
  output logic [1:0]      spr_pri,
  output logic            spr_hflip,
  output logic            spr_vflip,
  output logic            spr_size
);
  localparam int TOTAL  = MAIN_BYTES + AUX_BYTES;
  localparam int PTR_W  = $clog2(TOTAL);
  localparam int AUX_AW = $clog2(AUX_BYTES);

  logic             wr_fire, rd_fire;
  logic [PTR_W-1:0] ptr_q, ld_val, aux_off;
  logic             in_aux;
  logic [1:0]       lane_sel;
  logic [7:0]       lane_a [LANES];
  logic [7:0]       lane_b [LANES];
  logic [7:0]       aux_a, aux_b;
  logic             sel_aux_q;
  logic [1:0]       sel_lane_q;
  logic [1:0]       pair_q;
  spr_attr_t        attr;

  assign wr_fire  = host_wr & ~host_ld;
  assign rd_fire  = host_rd & ~host_ld & ~host_wr;
  assign ld_val   = {{(PTR_W-LD_W){1'b0}}, addr_hi, addr_lo};
  assign in_aux   = (ptr_q >= PTR_W'(MAIN_BYTES));
  assign aux_off  = ptr_q - PTR_W'(MAIN_BYTES);
  assign lane_sel = ptr_q[1:0];

  spr_host_ptr #(.TOTAL(TOTAL), .PTR_W(PTR_W)) ptr_i (
    .clk(clk), .rst(rst), .ld(host_ld), .ld_val(ld_val),
    .step(wr_fire | rd_fire), .ptr(ptr_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    spr_byte_ram #(.DEPTH(N_SPR), .AW(IDX_W)) ram_i (
      .clk(clk), .rst(rst),
      .we(wr_fire & ~in_aux & (lane_sel == 2'(k))),
      .waddr(ptr_q[IDX_W+1:2]), .wdata(wdata),
      .ra_en(rd_fire), .ra_addr(ptr_q[IDX_W+1:2]), .ra_data(lane_a[k]),
      .rb_en(1'b1), .rb_addr(spr_idx), .rb_data(lane_b[k])
    );
  end

  spr_byte_ram #(.DEPTH(AUX_BYTES), .AW(AUX_AW)) aux_i (
    .clk(clk), .rst(rst),
    .we(wr_fire & in_aux), .waddr(aux_off[AUX_AW-1:0]), .wdata(wdata),
    .ra_en(rd_fire), .ra_addr(aux_off[AUX_AW-1:0]), .ra_data(aux_a),
    .rb_en(1'b1), .rb_addr(spr_idx[IDX_W-1:2]), .rb_data(aux_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_aux_q  <= 1'b0;
      sel_lane_q <= '0;
      pair_q     <= '0;
    end else begin
      pair_q <= spr_idx[1:0];
      if (rd_fire) begin
        sel_aux_q  <= in_aux;
        sel_lane_q <= lane_sel;
      end
    end
  end

  assign rdata = sel_aux_q ? aux_a : lane_a[sel_lane_q];

  spr_attr_decode dec_i (
    .b_xlo(lane_b[LANE_XLO]), .b_y(lane_b[LANE_Y]),
    .b_chr(lane_b[LANE_CHR]), .b_attr(lane_b[LANE_ATTR]),
    .b_aux(aux_b), .pair_sel(pair_q), .attr(attr)
  );

  assign spr_x     = attr.x;
  assign spr_y     = attr.y;
  assign spr_chr   = attr.chr;
  assign spr_pal   = attr.pal;
  assign spr_pri   = attr.pri;
  assign spr_hflip = attr.hflip;
  assign spr_vflip = attr.vflip;
  assign spr_size  = attr.size;
endmodule

// File: rtl/spr_attr_mem_chk.sv
module spr_attr_mem_chk #(
  parameter int TOTAL = 544,
  parameter int PTR_W = 10,
  parameter int HI_W  = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             host_ld,
  input logic [7:0]       addr_lo,
  input logic [HI_W-1:0]  addr_hi,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       rdata,
  input logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TOTAL - 1);

  a_r1_reset_ptr: assert property (@(posedge clk) rst |=> ptr == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    host_ld |=> ptr == PTR_W'({$past(addr_hi), $past(addr_lo)}));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!host_ld && (host_wr || host_rd) && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (!host_ld && (host_wr || host_rd) && ptr == LAST) |=> ptr == '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!host_rd || host_ld || host_wr) |=> $stable(rdata));

  a_r5_range: assert property (@(posedge clk) disable iff (rst) ptr <= LAST);

  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!host_ld && !host_wr && !host_rd) |=> $stable(ptr));
endmodule

bind spr_attr_mem spr_attr_mem_chk #(.TOTAL(TOTAL), .PTR_W(PTR_W), .HI_W(HI_W)) chk_i (
  .clk(clk), .rst(rst), .host_ld(host_ld), .addr_lo(addr_lo), .addr_hi(addr_hi),
  .host_wr(host_wr), .host_rd(host_rd), .rdata(rdata), .ptr(ptr_q)
);

// File: tb/spr_attr_mem_tb_top.sv
module spr_attr_mem_tb_top;
  localparam int N = 128;
  localparam int TOT = 544;

  logic clk = 0, rst = 1;
  logic host_ld = 0, host_wr = 0, host_rd = 0;
  logic [7:0] addr_lo = 0, wdata = 0;
  logic [0:0] addr_hi = 0;
  logic [7:0] rdata;
  logic [6:0] spr_idx = 0;
  logic [8:0] spr_x, spr_chr;
  logic [7:0] spr_y;
  logic [2:0] spr_pal;
  logic [1:0] spr_pri;
  logic spr_hflip, spr_vflip, spr_size;

  int n_chk = 0, n_fail = 0;
  int exp_mem [TOT];
  bit done = 0;

  always #2 clk = ~clk;

  spr_attr_mem dut_i (
    .clk(clk), .rst(rst), .host_ld(host_ld), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .host_wr(host_wr), .wdata(wdata), .host_rd(host_rd), .rdata(rdata),
    .spr_idx(spr_idx), .spr_x(spr_x), .spr_y(spr_y), .spr_chr(spr_chr),
    .spr_pal(spr_pal), .spr_pri(spr_pri), .spr_hflip(spr_hflip),
    .spr_vflip(spr_vflip), .spr_size(spr_size)
  );

  function automatic int pat(int a);
    return (a * 73 + 29 + a / 256) % 256;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(int a);
    @(negedge clk);
    host_ld = 1; addr_lo = 8'(a); addr_hi = 1'(a >> 8);
    @(negedge clk);
    host_ld = 0;
  endtask

  task automatic do_write(int d);
    @(negedge clk);
    host_wr = 1; wdata = 8'(d);
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic do_read(output int d);
    @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    d = int'(rdata);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d, prev;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(rdata == 0, "R1 rdata", int'(rdata), 0);
    check(spr_x == 0 && spr_chr == 0 && spr_y == 0, "R1 render", int'(spr_x), 0);

    // R3 fill all bytes sequentially, pointer walks through both tables
    do_load(0);
    for (int a = 0; a < TOT; a++) begin
      exp_mem[a] = pat(a);
      do_write(exp_mem[a]);
    end
    // R6: pointer wrapped to 0 after 544 writes; R4/R5 read everything back
    for (int a = 0; a < TOT; a++) begin
      do_read(d);
      check(d == exp_mem[a], a < 512 ? "R4 R5 primary" : "R4 R5 secondary", d, exp_mem[a]);
    end
    do_read(d);
    check(d == exp_mem[0], "R6 wrap", d, exp_mem[0]);

    // R8 R9 R10 renderer sweep
    for (int s = 0; s < N; s++) begin
      int b0, b1, b2, b3, pr;
      @(negedge clk);
      spr_idx = 7'(s);
      @(negedge clk);
      b0 = exp_mem[4*s]; b1 = exp_mem[4*s+1]; b2 = exp_mem[4*s+2]; b3 = exp_mem[4*s+3];
      pr = (exp_mem[512 + s/4] >> (2*(s%4))) & 3;
      check(int'(spr_x) == ((pr >> 1) * 256 + b0), "R10 x", int'(spr_x), (pr >> 1) * 256 + b0);
      check(int'(spr_size) == (pr & 1), "R10 size", int'(spr_size), pr & 1);
      check(int'(spr_y) == b1, "R8 y", int'(spr_y), b1);
      check(int'(spr_chr) == ((b3 & 1) * 256 + b2), "R9 chr", int'(spr_chr), (b3 & 1) * 256 + b2);
      check(int'(spr_pal) == ((b3 >> 1) & 7), "R9 pal", int'(spr_pal), (b3 >> 1) & 7);
      check(int'(spr_pri) == ((b3 >> 4) & 3), "R9 pri", int'(spr_pri), (b3 >> 4) & 3);
      check(int'(spr_hflip) == ((b3 >> 6) & 1), "R9 hflip", int'(spr_hflip), (b3 >> 6) & 1);
      check(int'(spr_vflip) == ((b3 >> 7) & 1), "R9 vflip", int'(spr_vflip), (b3 >> 7) & 1);
    end

    // R2 load with top bit, then step across the table boundary (R5)
    do_load(511);
    do_read(d);
    check(d == exp_mem[511], "R2 load 511", d, exp_mem[511]);
    do_read(d);
    check(d == exp_mem[512], "R5 boundary", d, exp_mem[512]);

    // R2 load wins over a same-cycle write
    @(negedge clk);
    host_ld = 1; host_wr = 1; wdata = 8'hEE; addr_lo = 8'(300); addr_hi = 1'b1;
    @(negedge clk);
    host_ld = 0; host_wr = 0;
    do_read(d);
    check(d == exp_mem[300], "R2 load priority", d, exp_mem[300]);

    // R7 joint write and read: write only, rdata held, single step
    prev = d;
    do_load(10);
    @(negedge clk);
    host_wr = 1; host_rd = 1; wdata = 8'h5A;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    exp_mem[10] = 8'h5A;
    check(int'(rdata) == prev, "R7 rdata held", int'(rdata), prev);
    do_read(d);
    check(d == exp_mem[11], "R7 single step", d, exp_mem[11]);
    do_load(10);
    do_read(d);
    check(d == 8'h5A, "R7 write done", d, 8'h5A);

    // R4 rdata holds while idle
    repeat (3) @(negedge clk);
    check(int'(rdata) == 8'h5A, "R4 hold", int'(rdata), 8'h5A);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule